// File: doc/BRIEF.md
# Dual-Convention Parallel Display Host Port

This block sits on the display side of an asynchronous parallel microprocessor bus and turns host bus cycles into clean, single-clock events for the rest of the display controller. A static strap input picks one of two bus conventions. In the enable-strobe convention, one line gives the direction and a separate enable strobe qualifies the transfer. In the split-strobe convention, separate active-low write and read strobes each mark a transfer and its direction.

Every cycle is qualified by an active-low select and split by a data/command line. The result is one of four cycle kinds: command write, data write, status read or data read. Writes leave the block as a one-cycle valid pulse that carries the captured byte and a data/command flag, and they feed a command register or a display-data write port. Reads drive the bus through an output enable. A status read returns a ready bit that is low while the core is busy, and a data read returns the byte offered by the core. All bus inputs pass through a shared synchroniser, so the direction, select, data/command level and data byte stay aligned with each other.

Top module: `disp_host_port`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first bus cycle, `wr_valid` is 0, `bus_oe` is 0 and `bus_out` is 0.
- R2: With `mode_enstb`=1, a cycle where `ln_a`=0 (write direction) and `ln_b` pulses high produces a write that carries the byte present on `bus_in` while `ln_b` was high.
- R3: With `mode_enstb`=0, a low pulse on `ln_a` (active-low write strobe) produces a write that carries the byte present on `bus_in` while `ln_a` was low.
- R4: `wr_is_data` equals the `dc_sel` level held during the write strobe: 0 marks a command byte and 1 marks a display-data byte.
- R5: While `sel_n` is high, strobes produce no write pulse, and `bus_oe` stays 0.
- R6: A selected read with `dc_sel`=0 drives a status byte whose bit 7 is the inverse of `core_busy` (0 while busy) and whose bits 6..0 are 0.
- R7: A selected read with `dc_sel`=1 drives `core_rd_data` onto `bus_out`.
- R8: `bus_oe` is 1 only during a selected read cycle. It is 0 during writes and returns to 0 within a few cycles after the read strobe ends.
- R9: Each selected write strobe produces exactly one `wr_valid` pulse, one clock cycle wide, issued after the strobe ends.
- R10: Read cycles produce no `wr_valid` pulse. In the enable-strobe convention this is `ln_a`=1 with `ln_b` high; in the split-strobe convention it is `ln_b` low.
- R11: The byte and data/command level are taken from the point where the strobe ends, so a change of `bus_in` or `dc_sel` at the same moment the strobe ends does not alter the captured write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_enstb | input | 1 | Strap: 1 = enable-strobe convention, 0 = split-strobe convention |
| sel_n | input | 1 | Active-low select for the port |
| dc_sel | input | 1 | 0 = command/status, 1 = display data |
| ln_a | input | 1 | Direction line (1 read, 0 write), or active-low write strobe |
| ln_b | input | 1 | Active-high enable strobe, or active-low read strobe |
| bus_in | input | DATA_W | Bus data from the host |
| bus_out | output | DATA_W | Bus data to the host during reads |
| bus_oe | output | 1 | Output enable for the bus pad drivers |
| core_busy | input | 1 | Core busy flag, high while busy |
| core_rd_data | input | DATA_W | Display data offered for data reads |
| wr_valid | output | 1 | One-cycle pulse for each accepted write |
| wr_is_data | output | 1 | Flag for the write: 1 data, 0 command |
| wr_byte | output | DATA_W | Captured write byte |

## Verification
The bench builds the port with DATA_W=8 and SYNC_STAGES=2. The 8-bit width puts the busy bit at bit 7 and lets random bytes reach every data code. The two-stage synchroniser keeps latency short, so a strobe held for six cycles covers the whole pipeline and the post-strobe window stays small. Random cycles mix both conventions, both data/command levels, deselected cycles and busy states. Directed cases change the data and data/command level at the very moment the strobe ends, to check capture alignment.

// File: rtl/dhp_pkg.sv
package dhp_pkg;
  typedef enum logic [1:0] {
    XFER_IDLE = 2'd0,
    XFER_WR   = 2'd1,
    XFER_RD   = 2'd2
  } xfer_e;
endpackage

// File: rtl/dhp_rst_sync.sv
module dhp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q   <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_n_out <= stage_q;
    end
  end
endmodule

// File: rtl/dhp_sync.sv
module dhp_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] st_d;
    if (i == 0) begin : g_first
      assign st_d = d;
    end else begin : g_next
      assign st_d = st_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= RST_VAL;
      else        st_q[i] <= st_d;
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/dhp_decode.sv
module dhp_decode
  import dhp_pkg::*;
(
  input  logic  mode_enstb,
  input  logic  sel_n_s,
  input  logic  ln_a_s,
  input  logic  ln_b_s,
  output xfer_e kind
);
  always_comb begin
    kind = XFER_IDLE;
    if (!sel_n_s) begin
      if (mode_enstb) begin
        // direction line plus active-high enable strobe
        if (ln_b_s) kind = ln_a_s ? XFER_RD : XFER_WR;
      end else begin
        // split active-low strobes, write wins on overlap
        if (!ln_a_s)      kind = XFER_WR;
        else if (!ln_b_s) kind = XFER_RD;
      end
    end
  end
endmodule

// File: rtl/disp_host_port.sv
module disp_host_port
  import dhp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_enstb,
  input  logic              sel_n,
  input  logic              dc_sel,
  input  logic              ln_a,
  input  logic              ln_b,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic              core_busy,
  input  logic [DATA_W-1:0] core_rd_data,
  output logic              wr_valid,
  output logic              wr_is_data,
  output logic [DATA_W-1:0] wr_byte
);
  localparam int SW = DATA_W + 4;
  // select bit resets inactive so the flush after reset cannot fake a strobe
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic              rst_sync_n;
  logic [SW-1:0]     sync_q;
  logic              sel_n_s, ln_a_s, ln_b_s, dc_s;
  logic [DATA_W-1:0] bus_s;
  xfer_e             kind;
  logic              wr_act, rd_act, wr_end;
  logic [DATA_W-1:0] status_byte;

  logic              wr_act_q, wr_act_d;
  logic [DATA_W-1:0] hold_byte_q, hold_byte_d;
  logic              hold_dc_q, hold_dc_d;
  logic              wr_valid_d, wr_is_data_d;
  logic [DATA_W-1:0] wr_byte_d;
  logic              bus_oe_d;
  logic [DATA_W-1:0] bus_out_d;

  dhp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dhp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({sel_n, ln_a, ln_b, dc_sel, bus_in}),
    .q     (sync_q)
  );

  assign {sel_n_s, ln_a_s, ln_b_s, dc_s, bus_s} = sync_q;

  dhp_decode u_dec (
    .mode_enstb (mode_enstb),
    .sel_n_s    (sel_n_s),
    .ln_a_s     (ln_a_s),
    .ln_b_s     (ln_b_s),
    .kind       (kind)
  );

  assign wr_act      = (kind == XFER_WR);
  assign rd_act      = (kind == XFER_RD);
  assign wr_end      = wr_act_q & ~wr_act;
  assign status_byte = {~core_busy, {(DATA_W-1){1'b0}}};

  // next-state logic
  always_comb begin
    wr_act_d     = wr_act;
    hold_byte_d  = hold_byte_q;
    hold_dc_d    = hold_dc_q;
    wr_valid_d   = wr_end;
    wr_is_data_d = wr_is_data;
    wr_byte_d    = wr_byte;
    bus_oe_d     = rd_act;
    bus_out_d    = '0;
    if (wr_act) begin
      hold_byte_d = bus_s;
      hold_dc_d   = dc_s;
    end
    if (wr_end) begin
      wr_byte_d    = hold_byte_q;
      wr_is_data_d = hold_dc_q;
    end
    if (rd_act) bus_out_d = dc_s ? core_rd_data : status_byte;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_act_q    <= 1'b0;
      hold_byte_q <= '0;
      hold_dc_q   <= 1'b0;
      wr_valid    <= 1'b0;
      wr_is_data  <= 1'b0;
      wr_byte     <= '0;
      bus_oe      <= 1'b0;
      bus_out     <= '0;
    end else begin
      wr_act_q    <= wr_act_d;
      hold_byte_q <= hold_byte_d;
      hold_dc_q   <= hold_dc_d;
      wr_valid    <= wr_valid_d;
      wr_is_data  <= wr_is_data_d;
      wr_byte     <= wr_byte_d;
      bus_oe      <= bus_oe_d;
      bus_out     <= bus_out_d;
    end
  end

  // reset holds the outputs quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !bus_oe));

  // a deselected port never drives the bus
  p_desel_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_n_s |=> !bus_oe);

  // each write pulse is one cycle wide
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_valid |=> !wr_valid);

  // the write byte only moves together with a write pulse
  p_byte_moves_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(wr_byte) |-> wr_valid);
endmodule

// File: tb/disp_host_port_tb.sv
module disp_host_port_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_enstb, sel_n, dc_sel, ln_a, ln_b, core_busy;
  logic [DW-1:0] bus_in, core_rd_data, bus_out, wr_byte;
  logic          bus_oe, wr_valid, wr_is_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int            pulse_cnt;
  bit            oe_seen;
  logic [DW-1:0] last_byte;
  logic          last_dc;

  always #5 clk = ~clk;

  disp_host_port #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_enstb(mode_enstb), .sel_n(sel_n),
    .dc_sel(dc_sel), .ln_a(ln_a), .ln_b(ln_b), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .core_busy(core_busy),
    .core_rd_data(core_rd_data), .wr_valid(wr_valid),
    .wr_is_data(wr_is_data), .wr_byte(wr_byte)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      pulse_cnt = pulse_cnt + 1;
      last_byte = wr_byte;
      last_dc   = wr_is_data;
    end
    if (bus_oe) oe_seen = 1'b1;
  end

  function automatic logic [DW-1:0] exp_read(logic dc, logic busy, logic [DW-1:0] d);
    return dc ? d : {~busy, 7'b0};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(logic m);
    @(negedge clk);
    sel_n = 1'b1;
    wait_neg(4);
    mode_enstb = m;
    ln_a = 1'b1;
    ln_b = m ? 1'b0 : 1'b1;
    wait_neg(4);
  endtask

  task automatic do_write(logic dc, logic [DW-1:0] d, logic sel, bit skew, string req);
    @(negedge clk);
    pulse_cnt = 0; oe_seen = 1'b0;
    sel_n = ~sel; dc_sel = dc; bus_in = d;
    ln_a = 1'b0;
    if (mode_enstb) ln_b = 1'b1;
    wait_neg(6);
    if (mode_enstb) ln_b = 1'b0; else ln_a = 1'b1;
    if (skew) begin bus_in = ~d; dc_sel = ~dc; end
    @(negedge clk);
    ln_a = 1'b1;
    wait_neg(8);
    if (sel) begin
      check(pulse_cnt == 1, "R9 one pulse per write", pulse_cnt, 1);
      check(last_byte == d, req, last_byte, d);
      check(last_dc == dc, "R4 data/command flag", last_dc, dc);
    end else begin
      check(pulse_cnt == 0, "R5 deselected write ignored", pulse_cnt, 0);
    end
    check(!oe_seen, "R8 no drive during write", oe_seen, 0);
  endtask

  task automatic do_read(logic dc, logic busy, logic [DW-1:0] d, logic sel);
    logic [DW-1:0] e;
    @(negedge clk);
    pulse_cnt = 0; oe_seen = 1'b0;
    sel_n = ~sel; dc_sel = dc; core_busy = busy; core_rd_data = d;
    if (mode_enstb) begin ln_a = 1'b1; ln_b = 1'b1; end
    else ln_b = 1'b0;
    wait_neg(6);
    e = exp_read(dc, busy, d);
    if (sel) begin
      check(bus_oe == 1'b1, "R8 drive during read", bus_oe, 1);
      check(bus_out == e, dc ? "R7 data read" : "R6 status read", bus_out, e);
    end else begin
      check(bus_oe == 1'b0, "R5 deselected read no drive", bus_oe, 0);
    end
    ln_b = mode_enstb ? 1'b0 : 1'b1;
    wait_neg(5);
    check(bus_oe == 1'b0, "R8 drive ends after read", bus_oe, 0);
    check(pulse_cnt == 0, "R10 read gives no write pulse", pulse_cnt, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    pulse_cnt = 0; oe_seen = 1'b0; last_byte = '0; last_dc = 1'b0;
    rst_n = 1'b1; mode_enstb = 1'b0; sel_n = 1'b1; dc_sel = 1'b0;
    ln_a = 1'b1; ln_b = 1'b1; bus_in = '0; core_busy = 1'b0; core_rd_data = '0;
    #1 rst_n = 1'b0;
    wait_neg(3);
    check(wr_valid == 1'b0, "R1 reset wr_valid", wr_valid, 0);
    check(bus_oe == 1'b0, "R1 reset bus_oe", bus_oe, 0);
    check(bus_out == '0, "R1 reset bus_out", bus_out, 0);
    rst_n = 1'b1;
    wait_neg(6);
    check(wr_valid == 1'b0 && pulse_cnt == 0, "R1 quiet after reset", pulse_cnt, 0);
    check(bus_oe == 1'b0, "R1 bus_oe after reset", bus_oe, 0);

    // directed: both conventions, both flags, skewed release, deselected
    set_mode(1'b1);
    do_write(1'b0, 8'hA5, 1'b1, 1'b0, "R2 enable-strobe write byte");
    do_write(1'b1, 8'h3C, 1'b1, 1'b1, "R11 capture at strobe end");
    do_write(1'b1, 8'hFF, 1'b0, 1'b0, "R5 deselected");
    do_read(1'b0, 1'b1, 8'h00, 1'b1);
    do_read(1'b1, 1'b0, 8'h81, 1'b1);
    set_mode(1'b0);
    do_write(1'b1, 8'h5A, 1'b1, 1'b0, "R3 split-strobe write byte");
    do_write(1'b0, 8'hC3, 1'b1, 1'b1, "R11 capture at strobe end");
    do_read(1'b0, 1'b0, 8'h00, 1'b1);
    do_read(1'b1, 1'b1, 8'h7E, 1'b1);
    do_read(1'b1, 1'b0, 8'h11, 1'b0);

    // constrained random
    for (int n = 0; n < 160; n++) begin
      logic m, dc, sel, bsy;
      logic [DW-1:0] d;
      m   = 1'($urandom_range(0, 1));
      dc  = 1'($urandom_range(0, 1));
      sel = ($urandom_range(0, 9) != 0);
      bsy = 1'($urandom_range(0, 1));
      d   = 8'($urandom);
      if (m != mode_enstb) set_mode(m);
      if ($urandom_range(0, 1) == 1)
        do_write(dc, d, sel, ($urandom_range(0, 2) == 0),
                 m ? "R2 random write" : "R3 random write");
      else
        do_read(dc, bsy, d, sel);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule